// File: doc/BRIEF.md
# Parallel Rectangle Overlap Node Tester

This block is one node of a two-dimensional spatial index held in hardware. The node is a grid of NX by NY location slots. Each slot keeps a minimum bounding rectangle (MBR), a valid bit and a pointer to a child node or to a stored object. Besides its slots, the node keeps a single flag that marks it as a leaf. A traversal engine outside the block fills the slots one at a time through a load port. It then presents a query rectangle and gets back, one clock later, a hit bit for every slot together with every slot's pointer and the node's leaf flag.

The overlap test runs in every slot at once. No split point is computed and no slot is visited in sequence. The traversal engine uses the leaf flag to decide whether a hit pointer names an object to report or a child node to test next. A small controller has two states. IDLE means no result is being reported this cycle. REPORT means the result registers hold a result that was captured on the previous edge. The transition IDLE to REPORT is taken on a sampled query. REPORT to REPORT is taken on a query that follows directly. REPORT to IDLE and IDLE to IDLE are taken when query_valid is low.

Top module: `mbr_node_tester`

## Requirements
- R1: After reset, result_valid, hit_vec, ptr_vec and result_leaf are all zero, and every slot is invalid.
- R2: A cycle with load_en high writes the slot at column load_x and row load_y, which is slot index load_y*NX+load_x. That slot's hit is bit index of hit_vec, and its pointer is ptr_vec[index*PW +: PW].
- R3: A valid slot hits when q_lo_x <= s.hi_x, s.lo_x <= q_hi_x, q_lo_y <= s.hi_y and s.lo_y <= q_hi_y. All four comparisons are unsigned on CW bits. A rectangle that only touches the slot on an edge or a corner counts as a hit.
- R4: A slot whose valid bit is clear never hits. This covers slots never loaded and slots reloaded with load_valid low.
- R5: Every result carries the stored pointers of all slots, whether they hit or not.
- R6: result_valid is high in the cycle after each cycle with query_valid high, and low otherwise. Queries on consecutive cycles give results on consecutive cycles.
- R7: leaf_we high writes leaf_in into the node's leaf flag. Each result returns the flag as it was when the query was sampled.
- R8: hit_vec, ptr_vec and result_leaf hold their last values in every cycle that follows a cycle without a query.
- R9: A load or leaf write in the same cycle as a query has no effect on that query's result. The result reflects the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write one slot this cycle |
| load_x | input | XW | Column of the slot to write |
| load_y | input | YW | Row of the slot to write |
| load_valid | input | 1 | Valid bit to store |
| load_lo_x | input | CW | Low corner x |
| load_lo_y | input | CW | Low corner y |
| load_hi_x | input | CW | High corner x |
| load_hi_y | input | CW | High corner y |
| load_ptr | input | PW | Child or object pointer |
| leaf_we | input | 1 | Write the leaf flag |
| leaf_in | input | 1 | New leaf flag value |
| query_valid | input | 1 | Sample the query rectangle this cycle |
| q_lo_x | input | CW | Query low x |
| q_lo_y | input | CW | Query low y |
| q_hi_x | input | CW | Query high x |
| q_hi_y | input | CW | Query high y |
| result_valid | output | 1 | One-cycle result strobe |
| hit_vec | output | NX*NY | Per-slot overlap hits |
| ptr_vec | output | NX*NY*PW | All slot pointers, slot 0 in the low bits |
| result_leaf | output | 1 | Leaf flag that goes with the result |

## Verification
Every result is due exactly one edge after the query is sampled. A load or leaf write lands on the same edge that captures a concurrent query, so it shows up only in the next query's result. The bench model updates on each rising edge from the inputs driven at the previous falling edge. It evaluates the query against its stored contents before it applies any load from that cycle. All outputs are compared with the model at every falling edge, so a result that arrives a cycle early or late, or that fails to hold between queries, is caught.

// File: rtl/mbr_node_pkg.sv
package mbr_node_pkg;
    localparam int unsigned DEF_COORD_W = 16;
    localparam int unsigned DEF_PTR_W   = 16;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } node_state_e;
endpackage

// File: rtl/mbr_overlap_cmp.sv
module mbr_overlap_cmp #(
    parameter int unsigned CW = 16
) (
    input  logic          s_valid,
    input  logic [CW-1:0] s_lo_x,
    input  logic [CW-1:0] s_lo_y,
    input  logic [CW-1:0] s_hi_x,
    input  logic [CW-1:0] s_hi_y,
    input  logic [CW-1:0] q_lo_x,
    input  logic [CW-1:0] q_lo_y,
    input  logic [CW-1:0] q_hi_x,
    input  logic [CW-1:0] q_hi_y,
    output logic          hit
);
    logic x_ok;
    logic y_ok;

    // Inclusive bounds: touching edges count as overlap.
    always_comb begin
        x_ok = (q_lo_x <= s_hi_x) && (s_lo_x <= q_hi_x);
        y_ok = (q_lo_y <= s_hi_y) && (s_lo_y <= q_hi_y);
        hit  = s_valid && x_ok && y_ok;
    end
endmodule

// File: rtl/mbr_slot.sv
module mbr_slot #(
    parameter int unsigned CW = 16,
    parameter int unsigned PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_valid,
    input  logic [CW-1:0] wr_lo_x,
    input  logic [CW-1:0] wr_lo_y,
    input  logic [CW-1:0] wr_hi_x,
    input  logic [CW-1:0] wr_hi_y,
    input  logic [PW-1:0] wr_ptr,
    input  logic [CW-1:0] q_lo_x,
    input  logic [CW-1:0] q_lo_y,
    input  logic [CW-1:0] q_hi_x,
    input  logic [CW-1:0] q_hi_y,
    output logic          hit,
    output logic [PW-1:0] ptr
);
    logic          vld_q;
    logic [CW-1:0] lo_x_q, lo_y_q, hi_x_q, hi_y_q;
    logic [PW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            lo_x_q <= '0;
            lo_y_q <= '0;
            hi_x_q <= '0;
            hi_y_q <= '0;
            ptr_q  <= '0;
        end else if (wr_en) begin
            vld_q  <= wr_valid;
            lo_x_q <= wr_lo_x;
            lo_y_q <= wr_lo_y;
            hi_x_q <= wr_hi_x;
            hi_y_q <= wr_hi_y;
            ptr_q  <= wr_ptr;
        end
    end

    mbr_overlap_cmp #(.CW(CW)) u_cmp (
        .s_valid (vld_q),
        .s_lo_x  (lo_x_q),
        .s_lo_y  (lo_y_q),
        .s_hi_x  (hi_x_q),
        .s_hi_y  (hi_y_q),
        .q_lo_x  (q_lo_x),
        .q_lo_y  (q_lo_y),
        .q_hi_x  (q_hi_x),
        .q_hi_y  (q_hi_y),
        .hit     (hit)
    );

    assign ptr = ptr_q;
endmodule

// File: rtl/mbr_node_tester.sv
module mbr_node_tester
    import mbr_node_pkg::*;
#(
    parameter int unsigned NX = 2,
    parameter int unsigned NY = 2,
    parameter int unsigned CW = DEF_COORD_W,
    parameter int unsigned PW = DEF_PTR_W,
    localparam int unsigned NS = NX * NY,
    localparam int unsigned XW = (NX > 1) ? $clog2(NX) : 1,
    localparam int unsigned YW = (NY > 1) ? $clog2(NY) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [XW-1:0]    load_x,
    input  logic [YW-1:0]    load_y,
    input  logic             load_valid,
    input  logic [CW-1:0]    load_lo_x,
    input  logic [CW-1:0]    load_lo_y,
    input  logic [CW-1:0]    load_hi_x,
    input  logic [CW-1:0]    load_hi_y,
    input  logic [PW-1:0]    load_ptr,
    input  logic             leaf_we,
    input  logic             leaf_in,
    input  logic             query_valid,
    input  logic [CW-1:0]    q_lo_x,
    input  logic [CW-1:0]    q_lo_y,
    input  logic [CW-1:0]    q_hi_x,
    input  logic [CW-1:0]    q_hi_y,
    output logic             result_valid,
    output logic [NS-1:0]    hit_vec,
    output logic [NS*PW-1:0] ptr_vec,
    output logic             result_leaf
);
    node_state_e state_q, state_d;

    logic [NS-1:0]    slot_hit;
    logic [NS*PW-1:0] slot_ptr;
    logic             leaf_q;
    logic [NS-1:0]    hit_q;
    logic [NS*PW-1:0] ptr_q;
    logic             rleaf_q;

    for (genvar g = 0; g < NS; g++) begin : g_slot
        logic sel;
        assign sel = load_en
                  && (load_x == XW'(g % NX))
                  && (load_y == YW'(g / NX));

        mbr_slot #(.CW(CW), .PW(PW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (sel),
            .wr_valid (load_valid),
            .wr_lo_x  (load_lo_x),
            .wr_lo_y  (load_lo_y),
            .wr_hi_x  (load_hi_x),
            .wr_hi_y  (load_hi_y),
            .wr_ptr   (load_ptr),
            .q_lo_x   (q_lo_x),
            .q_lo_y   (q_lo_y),
            .q_hi_x   (q_hi_x),
            .q_hi_y   (q_hi_y),
            .hit      (slot_hit[g]),
            .ptr      (slot_ptr[g*PW +: PW])
        );
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = query_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = query_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Node leaf flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       leaf_q <= 1'b0;
        else if (leaf_we) leaf_q <= leaf_in;
    end

    // Result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q   <= '0;
            ptr_q   <= '0;
            rleaf_q <= 1'b0;
        end else if (query_valid) begin
            hit_q   <= slot_hit;
            ptr_q   <= slot_ptr;
            rleaf_q <= leaf_q;
        end
    end

    // Outputs
    always_comb begin
        result_valid = (state_q == ST_REPORT);
        hit_vec      = hit_q;
        ptr_vec      = ptr_q;
        result_leaf  = rleaf_q;
    end
endmodule

// File: rtl/mbr_node_tester_chk.sv
module mbr_node_tester_chk #(
    parameter int unsigned NX = 2,
    parameter int unsigned NY = 2,
    parameter int unsigned CW = 16,
    parameter int unsigned PW = 16,
    localparam int unsigned NS = NX * NY,
    localparam int unsigned XW = (NX > 1) ? $clog2(NX) : 1,
    localparam int unsigned YW = (NY > 1) ? $clog2(NY) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_en,
    input logic [XW-1:0]    load_x,
    input logic [YW-1:0]    load_y,
    input logic             load_valid,
    input logic             query_valid,
    input logic             result_valid,
    input logic [NS-1:0]    hit_vec,
    input logic [NS*PW-1:0] ptr_vec,
    input logic             result_leaf
);
    logic [NS-1:0] ever_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ever_valid <= '0;
        end else if (load_en && load_valid) begin
            for (int i = 0; i < NS; i++) begin
                if (int'(load_y) * NX + int'(load_x) == i) ever_valid[i] <= 1'b1;
            end
        end
    end

    // R6: a sampled query yields a strobe on the next cycle
    a_r6_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        query_valid |=> result_valid);

    // R6: no strobe without a query
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !query_valid |=> !result_valid);

    // R8: results hold between queries
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !query_valid |=> ($stable(hit_vec) && $stable(ptr_vec) && $stable(result_leaf)));

    // R4: a slot never loaded as valid never hits
    a_r4_no_hit_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec & ~ever_valid) == '0);
endmodule

bind mbr_node_tester mbr_node_tester_chk #(.NX(NX), .NY(NY), .CW(CW), .PW(PW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_en      (load_en),
    .load_x       (load_x),
    .load_y       (load_y),
    .load_valid   (load_valid),
    .query_valid  (query_valid),
    .result_valid (result_valid),
    .hit_vec      (hit_vec),
    .ptr_vec      (ptr_vec),
    .result_leaf  (result_leaf)
);

// File: tb/mbr_node_tester_tb.sv
module mbr_node_tester_tb;
    localparam int NX = 2;
    localparam int NY = 2;
    localparam int CW = 16;
    localparam int PW = 16;
    localparam int NS = NX * NY;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_en = 1'b0;
    logic [0:0] load_x = '0;
    logic [0:0] load_y = '0;
    logic load_valid = 1'b0;
    logic [CW-1:0] load_lo_x = '0, load_lo_y = '0, load_hi_x = '0, load_hi_y = '0;
    logic [PW-1:0] load_ptr = '0;
    logic leaf_we = 1'b0, leaf_in = 1'b0;
    logic query_valid = 1'b0;
    logic [CW-1:0] q_lo_x = '0, q_lo_y = '0, q_hi_x = '0, q_hi_y = '0;
    logic result_valid;
    logic [NS-1:0] hit_vec;
    logic [NS*PW-1:0] ptr_vec;
    logic result_leaf;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mbr_node_tester #(.NX(NX), .NY(NY), .CW(CW), .PW(PW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .load_en(load_en), .load_x(load_x), .load_y(load_y), .load_valid(load_valid),
        .load_lo_x(load_lo_x), .load_lo_y(load_lo_y), .load_hi_x(load_hi_x), .load_hi_y(load_hi_y),
        .load_ptr(load_ptr), .leaf_we(leaf_we), .leaf_in(leaf_in),
        .query_valid(query_valid), .q_lo_x(q_lo_x), .q_lo_y(q_lo_y), .q_hi_x(q_hi_x), .q_hi_y(q_hi_y),
        .result_valid(result_valid), .hit_vec(hit_vec), .ptr_vec(ptr_vec), .result_leaf(result_leaf)
    );

    // Behavioural reference model
    int m_vld[NS], m_lx[NS], m_ly[NS], m_hx[NS], m_hy[NS], m_ptr[NS];
    int m_leaf;
    bit exp_rv;
    logic [NS-1:0] exp_hit;
    logic [NS*PW-1:0] exp_ptr;
    bit exp_leaf;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin
                m_vld[i] = 0; m_lx[i] = 0; m_ly[i] = 0; m_hx[i] = 0; m_hy[i] = 0; m_ptr[i] = 0;
            end
            m_leaf = 0; exp_rv = 0; exp_hit = '0; exp_ptr = '0; exp_leaf = 0;
        end else begin
            exp_rv = query_valid;
            if (query_valid) begin
                for (int i = 0; i < NS; i++) begin
                    exp_hit[i] = (m_vld[i] != 0) && (int'(q_lo_x) <= m_hx[i]) && (m_lx[i] <= int'(q_hi_x))
                              && (int'(q_lo_y) <= m_hy[i]) && (m_ly[i] <= int'(q_hi_y));
                    exp_ptr[i*PW +: PW] = PW'(m_ptr[i]);
                end
                exp_leaf = (m_leaf != 0);
            end
            if (load_en) begin
                int k;
                k = int'(load_y) * NX + int'(load_x);
                m_vld[k] = load_valid; m_lx[k] = load_lo_x; m_ly[k] = load_lo_y;
                m_hx[k] = load_hi_x; m_hy[k] = load_hi_y; m_ptr[k] = load_ptr;
            end
            if (leaf_we) m_leaf = leaf_in;
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (result_valid !== exp_rv) begin
                n_bad++;
                $display("FAIL R6 result_valid actual=%0b expected=%0b t=%0t", result_valid, exp_rv, $time);
            end
            n_cmp++;
            if (hit_vec !== exp_hit) begin
                n_bad++;
                $display("FAIL R3/R4/R8 hit_vec actual=%b expected=%b t=%0t", hit_vec, exp_hit, $time);
            end
            n_cmp++;
            if (ptr_vec !== exp_ptr) begin
                n_bad++;
                $display("FAIL R2/R5 ptr_vec actual=%h expected=%h t=%0t", ptr_vec, exp_ptr, $time);
            end
            n_cmp++;
            if (result_leaf !== exp_leaf) begin
                n_bad++;
                $display("FAIL R7 result_leaf actual=%0b expected=%0b t=%0t", result_leaf, exp_leaf, $time);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        load_en = 0; leaf_we = 0; query_valid = 0;
    endtask

    task automatic load(input int x, input int y, input bit v,
                        input int lx, input int ly, input int hx, input int hy, input int p);
        @(negedge clk);
        leaf_we = 0; query_valid = 0;
        load_en = 1; load_x = 1'(x); load_y = 1'(y); load_valid = v;
        load_lo_x = CW'(lx); load_lo_y = CW'(ly); load_hi_x = CW'(hx); load_hi_y = CW'(hy);
        load_ptr = PW'(p);
    endtask

    task automatic query(input int lx, input int ly, input int hx, input int hy);
        @(negedge clk);
        load_en = 0; leaf_we = 0;
        query_valid = 1;
        q_lo_x = CW'(lx); q_lo_y = CW'(ly); q_hi_x = CW'(hx); q_hi_y = CW'(hy);
    endtask

    task automatic set_leaf(input bit v);
        @(negedge clk);
        load_en = 0; query_valid = 0;
        leaf_we = 1; leaf_in = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state checked by the compare process during reset
        rst_n = 1;
        idle();
        // R2: fill slots at distinct (x, y)
        load(0, 0, 1, 10, 10, 20, 20, 16'h1111);
        load(1, 0, 1, 30, 10, 40, 20, 16'h2222);
        load(0, 1, 1, 10, 30, 20, 40, 16'h3333);
        load(1, 1, 1, 16'h8000, 16'h8000, 16'hFFFF, 16'hFFFF, 16'h4444);
        idle();
        // R3: disjoint, partial, containing, touching edge and corner
        query(0, 0, 5, 5);
        query(15, 15, 35, 15);
        query(0, 0, 100, 100);
        query(20, 20, 30, 30);
        query(40, 40, 50, 50);
        idle(); idle();                       // R8 hold
        // R3: unsigned compare at the top of the range
        query(16'h9000, 16'hF000, 16'hFFFF, 16'hFFFF);
        query(16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF);
        // R7: leaf flag
        set_leaf(1);
        query(10, 10, 10, 10);
        idle();
        // R4: invalidate a slot that would hit
        load(0, 0, 0, 10, 10, 20, 20, 16'hAAAA);
        query(12, 12, 14, 14);
        // R9: load and leaf write together with a query
        @(negedge clk);
        query_valid = 1; q_lo_x = 0; q_lo_y = 0; q_hi_x = 100; q_hi_y = 100;
        load_en = 1; load_x = 1; load_y = 0; load_valid = 0;
        load_lo_x = 0; load_lo_y = 0; load_hi_x = 0; load_hi_y = 0; load_ptr = 16'h5555;
        leaf_we = 1; leaf_in = 0;
        query(0, 0, 100, 100);
        idle();
        // R6: random back-to-back and spaced traffic
        for (int n = 0; n < 300; n++) begin
            int r;
            r = $urandom_range(0, 3);
            if (r == 0) load($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
                             $urandom_range(0,60), $urandom_range(0,60),
                             $urandom_range(40,100), $urandom_range(40,100), $urandom_range(0,65535));
            else if (r == 1) idle();
            else if (r == 2) set_leaf($urandom_range(0,1));
            else query($urandom_range(0,80), $urandom_range(0,80),
                       $urandom_range(20,120), $urandom_range(20,120));
        end
        idle(); idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule